// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a supervision timer that software must service on time. A 24-bit counter counts down while the timer runs. It is clocked by the bus clock through a fixed divide-by-four prescaler. Software restarts the count with a two-write key sequence on a dedicated register. If the count reaches zero before that happens, the block raises a timeout flag. If software has armed the reset option, it also pulses a chip-reset request.

A window register lets software reject a service that comes too early. While the timer runs, a key sequence that completes while the count is still above the window value counts as a fault, as does a broken key sequence. A warning-compare register raises an interrupt flag when the count passes a chosen value. Writes that turn the timer or the reset option on are held in a staging copy and only become active at the next complete key sequence. Once active, these settings can never be turned off by software.

Top module: `wdt_windowed`

## Requirements
- R1: After reset, the mode register reads 0, the timeout constant reads 0xFF, the counter reads 0xFF, the warning compare reads 0, the window compare reads 0xFFFFFF, and both `warn_irq` and `rst_req` are low.
- R2: Register offsets are: mode 0x00, timeout constant 0x04, feed 0x08, counter 0x0C, warning compare 0x14, window compare 0x18. A read loads `bus_rdata` on the clock edge that samples `bus_re`, and `bus_rdata` is 0 in every cycle with no read. The feed register and unmapped offsets read as 0. Mode bit layout: bit 0 run enable, bit 1 reset enable, bit 2 timeout flag, bit 3 warning flag.
- R3: Run enable and reset enable can only be set: writing 0 to them has no effect, and only a system reset clears them.
- R4: A write of 1 to mode bit 0 or bit 1 goes to a staging copy. The readable active bit changes only at the next valid feed.
- R5: A valid feed is a feed write with low byte 0xAA followed, as the very next feed write, by low byte 0x55. It reloads the counter from the timeout constant. A lone feed write whose low byte is not 0xAA is ignored.
- R6: While running, the block records a feed error in two cases. One is a 0xAA feed write followed by a feed write whose low byte is not 0x55. The other is a 0xAA/0x55 pair that completes while the counter is above the window compare value. A feed error is treated as a timeout.
- R7: The timeout flag sets on a timeout or a feed error. A mode write with bit 2 = 0 clears it, and a set in the same cycle wins over the clear.
- R8: On a timeout or feed error with reset enable active, `rst_req` goes high for exactly one cycle, in the cycle after the event. With reset enable inactive, it stays low.
- R9: While running, the counter decrements once every 4 clocks. While stopped, it changes only on a valid feed. Reads of offset 0x0C return the live value.
- R10: A prescaler tick at count 0 is a timeout, and the counter reloads from the timeout constant.
- R11: The warning flag sets in any running cycle whose count equals the warning compare. A mode write with bit 3 = 0 clears it, a set wins over a clear, and `warn_irq` equals the flag.
- R12: When a feed outcome (valid or error) falls on the same cycle as a tick at count 0, the feed outcome alone decides the result, and no separate timeout is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (5) | Register byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Registered read data |
| warn_irq | output | 1 | Warning interrupt request |
| rst_req | output | 1 | One-cycle chip-reset request |

## Verification
The hard case is a feed sequence whose second write lands on the same edge as the prescaler tick that finds the count at zero. There, reload by feed, window fault and timeout all compete. The bench places feeds at a sweep of delays across the expected expiry so that some completions hit exactly that tick, with the window both open and closed. The bench's reference model decides each such cycle by the feed outcome and compares flag, counter reads and `rst_req` every clock. A final check confirms that at least one collision actually occurred.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_TC   = 8'h04;
  localparam logic [7:0] OFS_FEED = 8'h08;
  localparam logic [7:0] OFS_CNT  = 8'h0C;
  localparam logic [7:0] OFS_WARN = 8'h14;
  localparam logic [7:0] OFS_WIN  = 8'h18;

  localparam int MB_EN   = 0;
  localparam int MB_RSTE = 1;
  localparam int MB_TOF  = 2;
  localparam int MB_WINT = 3;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_ARMED = 1'b1} seq_t;
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  assign tick = run && (div_q == LAST);
endmodule

// File: rtl/wdg_feed_seq.sv
module wdg_feed_seq import wdg_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       feed_we,
  input  logic [7:0] feed_byte,
  input  logic       running,
  input  logic       early,
  output logic       good,
  output logic       bad
);
  seq_t st_q;

  always_comb begin
    good = 1'b0;
    bad  = 1'b0;
    if (feed_we && st_q == SEQ_ARMED) begin
      if (feed_byte == KEY_SECOND) begin
        if (running && early) bad = 1'b1;
        else good = 1'b1;
      end else begin
        bad = running;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SEQ_IDLE;
    else if (feed_we)
      st_q <= (st_q == SEQ_IDLE && feed_byte == KEY_FIRST) ? SEQ_ARMED : SEQ_IDLE;
  end
endmodule

// File: rtl/wdg_downcount.sv
module wdg_downcount #(
  parameter int             CNT_W  = 24,
  parameter logic [CNT_W-1:0] RST_VAL = CNT_W'(8'hFF)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= RST_VAL;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/wdt_windowed.sv
module wdt_windowed import wdg_pkg::*; #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 24,
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              warn_irq,
  output logic              rst_req
);
  localparam logic [CNT_W-1:0] TC_RST  = CNT_W'(8'hFF);
  localparam logic [CNT_W-1:0] WIN_RST = '1;

  logic [CNT_W-1:0] tc_q, warn_q, win_q, cnt_q;
  logic en_q, rsten_q, en_stg, rsten_stg, tof_q, wint_q, rst_req_q;
  logic [DATA_W-1:0] rdata_q, rd_val;
  logic wr_mode, wr_tc, wr_feed, wr_warn, wr_win;
  logic tick, feed_good, feed_bad, timeout, fault, load, early;
  logic unused_hi;

  assign unused_hi = ^bus_wdata[DATA_W-1:CNT_W];

  assign wr_mode = bus_we && bus_addr == OFS_MODE[ADDR_W-1:0];
  assign wr_tc   = bus_we && bus_addr == OFS_TC[ADDR_W-1:0];
  assign wr_feed = bus_we && bus_addr == OFS_FEED[ADDR_W-1:0];
  assign wr_warn = bus_we && bus_addr == OFS_WARN[ADDR_W-1:0];
  assign wr_win  = bus_we && bus_addr == OFS_WIN[ADDR_W-1:0];

  assign early = cnt_q > win_q;

  wdg_prescale #(.DIV(PRESCALE)) pre_i (
    .clk(clk), .rst(rst), .run(en_q), .tick(tick)
  );

  wdg_feed_seq feed_i (
    .clk(clk), .rst(rst), .feed_we(wr_feed), .feed_byte(bus_wdata[7:0]),
    .running(en_q), .early(early), .good(feed_good), .bad(feed_bad)
  );

  assign timeout = tick && cnt_q == '0 && !(feed_good || feed_bad);
  assign fault   = timeout || feed_bad;
  assign load    = feed_good || fault;

  wdg_downcount #(.CNT_W(CNT_W), .RST_VAL(TC_RST)) cnt_i (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .load_val(tc_q), .cnt(cnt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q      <= TC_RST;
      warn_q    <= '0;
      win_q     <= WIN_RST;
      en_q      <= 1'b0;
      rsten_q   <= 1'b0;
      en_stg    <= 1'b0;
      rsten_stg <= 1'b0;
      tof_q     <= 1'b0;
      wint_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (wr_tc)   tc_q   <= bus_wdata[CNT_W-1:0];
      if (wr_warn) warn_q <= bus_wdata[CNT_W-1:0];
      if (wr_win)  win_q  <= bus_wdata[CNT_W-1:0];
      en_stg    <= en_stg    | (wr_mode & bus_wdata[MB_EN]);
      rsten_stg <= rsten_stg | (wr_mode & bus_wdata[MB_RSTE]);
      en_q      <= en_q    | (feed_good & en_stg);
      rsten_q   <= rsten_q | (feed_good & rsten_stg);
      tof_q     <= fault | (tof_q & ~(wr_mode & ~bus_wdata[MB_TOF]));
      wint_q    <= (en_q && cnt_q == warn_q) | (wint_q & ~(wr_mode & ~bus_wdata[MB_WINT]));
      rst_req_q <= fault & rsten_q;
    end
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      OFS_MODE[ADDR_W-1:0]: rd_val = DATA_W'({wint_q, tof_q, rsten_q, en_q});
      OFS_TC[ADDR_W-1:0]:   rd_val = DATA_W'(tc_q);
      OFS_CNT[ADDR_W-1:0]:  rd_val = DATA_W'(cnt_q);
      OFS_WARN[ADDR_W-1:0]: rd_val = DATA_W'(warn_q);
      OFS_WIN[ADDR_W-1:0]:  rd_val = DATA_W'(win_q);
      default:              rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else rdata_q <= bus_re ? rd_val : '0;
  end

  assign bus_rdata = rdata_q;
  assign warn_irq  = wint_q;
  assign rst_req   = rst_req_q;
endmodule

// File: rtl/wdt_windowed_chk.sv
module wdt_windowed_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             rst_req,
  input logic             tof,
  input logic             en,
  input logic             rsten,
  input logic             tick,
  input logic             load,
  input logic [CNT_W-1:0] cnt
);
  AST_REQ_NEEDS_RSTEN: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> rsten); // R8
  AST_REQ_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> tof); // R7
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (rst)
    en |=> en); // R3
  AST_RSTEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    rsten |=> rsten); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt)); // R9
  AST_REQ_AFTER_RELOAD: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(load)); // R10
endmodule

bind wdt_windowed wdt_windowed_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .rst_req(rst_req_q), .tof(tof_q), .en(en_q),
  .rsten(rsten_q), .tick(tick), .load(load), .cnt(cnt_q)
);

// File: tb/wdt_windowed_tb_top.sv
module wdt_windowed_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        warn_irq, rst_req;

  always #2.5 clk = ~clk;

  wdt_windowed dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .warn_irq(warn_irq), .rst_req(rst_req)
  );

  int checks = 0, failures = 0, cyc = 0, coll = 0, errs = 0;
  string cur_tag = "R1";

  // behavioural reference
  logic [23:0] m_tc, m_warn, m_win, m_cnt;
  int m_pre;
  bit m_en, m_rsten, m_sen, m_srsten, m_tof, m_wint, m_req, m_armed;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    bit tk, ok, bad, to, flt, mw;
    logic [7:0] b;
    if (rst) begin
      m_tc = 24'hFF; m_warn = 0; m_win = 24'hFFFFFF; m_cnt = 24'hFF; m_pre = 0;
      m_en = 0; m_rsten = 0; m_sen = 0; m_srsten = 0; m_tof = 0; m_wint = 0;
      m_req = 0; m_armed = 0; m_rd = 0;
    end else begin
      b = bus_wdata[7:0];
      if (bus_re) begin
        case (bus_addr)
          5'h00: m_rd = {28'd0, m_wint, m_tof, m_rsten, m_en};
          5'h04: m_rd = {8'd0, m_tc};
          5'h0C: m_rd = {8'd0, m_cnt};
          5'h14: m_rd = {8'd0, m_warn};
          5'h18: m_rd = {8'd0, m_win};
          default: m_rd = 0;
        endcase
      end else m_rd = 0;
      tk = m_en && m_pre == 3;
      ok = 0; bad = 0;
      if (bus_we && bus_addr == 5'h08) begin
        if (m_armed) begin
          m_armed = 0;
          if (b == 8'h55) begin
            if (m_en && m_cnt > m_win) bad = 1; else ok = 1;
          end else bad = m_en;
        end else m_armed = (b == 8'hAA);
      end
      if (tk && m_cnt == 0 && (ok || bad)) coll++;
      if (bad) errs++;
      to = tk && m_cnt == 0 && !ok && !bad;
      flt = to || bad;
      mw = bus_we && bus_addr == 5'h00;
      m_req = flt && m_rsten;
      m_wint = (m_en && m_cnt == m_warn) || (m_wint && !(mw && !bus_wdata[3]));
      m_tof = flt || (m_tof && !(mw && !bus_wdata[2]));
      if (ok || flt) m_cnt = m_tc; else if (tk) m_cnt = m_cnt - 1;
      m_pre = m_en ? (m_pre + 1) % 4 : 0;
      if (ok) begin m_en = m_en | m_sen; m_rsten = m_rsten | m_srsten; end
      if (mw) begin m_sen = m_sen | bus_wdata[0]; m_srsten = m_srsten | bus_wdata[1]; end
      if (bus_we && bus_addr == 5'h04) m_tc = bus_wdata[23:0];
      if (bus_we && bus_addr == 5'h14) m_warn = bus_wdata[23:0];
      if (bus_we && bus_addr == 5'h18) m_win = bus_wdata[23:0];
    end
  end

  task automatic chk(input bit c, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!c) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(bus_rdata === m_rd, cur_tag, bus_rdata, m_rd);
      chk(warn_irq === m_wint, "R11", {31'd0, warn_irq}, {31'd0, m_wint});
      chk(rst_req === m_req, "R8", {31'd0, rst_req}, {31'd0, m_req});
    end
    if (cyc > 150000) begin
      failures++; checks++;
      $display("FAIL R1 watchdog expired actual=%0d expected<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a);
    @(negedge clk); bus_addr = a; bus_re = 1;
    @(negedge clk); bus_re = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic feed();
    wr(5'h08, 32'hAA); wr(5'h08, 32'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_tag = "R1";
    chk(warn_irq === 0 && rst_req === 0, "R1", {30'd0, warn_irq, rst_req}, 0);
    rd(5'h00); rd(5'h04); rd(5'h0C); rd(5'h14); rd(5'h18);
    cur_tag = "R2";
    rd(5'h08); rd(5'h1C); idle(2);
    wr(5'h04, 32'd20); wr(5'h14, 32'd10); rd(5'h04); rd(5'h14);
    cur_tag = "R4";
    wr(5'h00, 32'h1); rd(5'h00); idle(8); rd(5'h0C);
    cur_tag = "R5";
    wr(5'h08, 32'h55); rd(5'h0C);
    feed(); rd(5'h00); rd(5'h0C);
    cur_tag = "R9";
    for (int i = 0; i < 12; i++) rd(5'h0C);
    cur_tag = "R10";
    idle(90); rd(5'h00); rd(5'h0C);
    cur_tag = "R7";
    wr(5'h00, 32'h0); rd(5'h00);
    cur_tag = "R3";
    wr(5'h00, 32'h0C); rd(5'h00);
    cur_tag = "R4";
    wr(5'h00, 32'h2); rd(5'h00); feed(); rd(5'h00);
    cur_tag = "R8";
    idle(95); rd(5'h00);
    cur_tag = "R6";
    wr(5'h08, 32'hAA); wr(5'h08, 32'h12); rd(5'h00);
    wr(5'h08, 32'hAA); wr(5'h08, 32'hAA); rd(5'h0C);
    wr(5'h18, 32'd8); feed(); rd(5'h00);
    idle(60); rd(5'h0C); feed(); rd(5'h0C);
    chk(errs >= 3, "R6", errs, 3);
    cur_tag = "R11";
    idle(30); wr(5'h00, 32'h4); rd(5'h00); idle(50); wr(5'h00, 32'h0); rd(5'h00);
    cur_tag = "R12";
    for (int w = 0; w < 2; w++) begin
      wr(5'h18, w == 0 ? 32'hFFFFFF : 32'd0);
      for (int k = 72; k < 96; k++) begin
        feed(); idle(k); rd(5'h0C);
      end
    end
    chk(coll > 0, "R12", coll, 1);
    idle(4);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule